// File: doc/BRIEF.md
# Four-Mode Configurable I/O Port

This block controls a register-mapped bidirectional port of `W` pins. Each pin takes its mode from two register bits: one in a configuration register and one in a data register. The pair selects one of four modes: floating input, input with a weak pull-up, driven low, or driven high. For every pin the block produces a pad output value, an output enable and a pull-up enable. A separate read path returns the pad levels after they pass through a synchronizer.

Two data-register bit positions double as requests to enter the low-power modes. A write that sets one of them produces a single-cycle request pulse, and the stored bit clears itself. A group of low pins, configured by parameter, always reads back as one on the pin path, so a narrower port variant can be modelled. The data and configuration bits behind those pins still store flags in the usual way. A small output-only port, which comes up all ones after reset, shares the same register interface.

Top module: `cfgio_port`

## Requirements
- R1: A pin whose (config, data) bits are 00 is a floating input: pad_oe=0 and pad_pu=0.
- R2: A pin with (config, data)=01 is an input with pull-up: pad_oe=0 and pad_pu=1.
- R3: A pin with (config, data)=10 drives low: pad_oe=1, pad_out=0, pad_pu=0.
- R4: A pin with (config, data)=11 drives high: pad_oe=1, pad_out=1, pad_pu=0.
- R5: Synchronous reset clears the data and config registers, so every pin is a floating input. The low-power request outputs are 0 during and after reset.
- R6: A read of register 2 (pin) returns the pad level after SYNC_STAGES clock edges. Pins below FORCE_LO (bits 0 to 3 by default) always read 1.
- R7: Reads of register 0 (data) and register 1 (config) return the last values written, including the bits under the forced-one pins. Bits HALT_BIT and IDLE_BIT of register 0 are the exception and always read 0.
- R8: A write to register 0 with bit HALT_BIT (7) set makes halt_req high for exactly the one cycle after the write edge.
- R9: A write to register 0 with bit IDLE_BIT (6) set makes idle_req high for exactly the one cycle after the write edge.
- R10: The OUT_W-bit output-only port (register 3) is all ones after reset. It changes only on a write to register 3, which loads the low OUT_W bits of wdata. Reading register 3 returns its value zero-extended.
- R11: rdata is registered. It updates on the edge where rd_en is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register select (0 data, 1 config, 3 output port) |
| wdata | input | W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read register select (0 data, 1 config, 2 pin, 3 output port) |
| rdata | output | W | Registered read data |
| pad_in | input | W | Pad input levels |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |
| pad_pu | output | W | Weak pull-up enables |
| halt_req | output | 1 | Single-cycle HALT request |
| idle_req | output | 1 | Single-cycle IDLE request |
| dout_port | output | OUT_W | Output-only port |

## Verification
The assertions assume a synchronous reset and register-interface inputs that are stable at each rising edge. They also assume that wr_addr and rd_addr are 2-bit codes with no undefined values. The bench drives every input on the falling edge and holds wr_en and rd_en for exactly one cycle per access, which satisfies these assumptions. It changes pad_in only on falling edges and waits out the synchronizer depth before it reads the pin register, so no pin result depends on a metastable sample.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CFG  = 2'd1,
    REG_PIN  = 2'd2,
    REG_DOUT = 2'd3
  } reg_sel_e;

  // mode = {config bit, data bit}
  typedef enum logic [1:0] {
    MODE_HIZ    = 2'b00,
    MODE_PULLUP = 2'b01,
    MODE_DRIVE0 = 2'b10,
    MODE_DRIVE1 = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/cfgio_pin_sync.sv
module cfgio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfgio_mode_cell.sv
module cfgio_mode_cell
  import cfgio_pkg::*;
(
  input  logic cfg_bit,
  input  logic dat_bit,
  output logic drv_out,
  output logic drv_oe,
  output logic pull_en
);
  pin_mode_e mode;
  assign mode = pin_mode_e'({cfg_bit, dat_bit});

  always_comb begin
    drv_out = 1'b0;
    drv_oe  = 1'b0;
    pull_en = 1'b0;
    unique case (mode)
      MODE_HIZ:    ;
      MODE_PULLUP: pull_en = 1'b1;
      MODE_DRIVE0: drv_oe  = 1'b1;
      MODE_DRIVE1: begin
        drv_oe  = 1'b1;
        drv_out = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cfgio_strobe.sv
module cfgio_strobe (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= fire;
  end
endmodule

// File: rtl/cfgio_port.sv
module cfgio_port
  import cfgio_pkg::*;
#(
  parameter int W           = 8,
  parameter int OUT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FORCE_LO    = 4,
  parameter int HALT_BIT    = 7,
  parameter int IDLE_BIT    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [W-1:0]     wdata,
  input  logic             rd_en,
  input  logic [1:0]       rd_addr,
  output logic [W-1:0]     rdata,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_pu,
  output logic             halt_req,
  output logic             idle_req,
  output logic [OUT_W-1:0] dout_port
);
  localparam logic [W-1:0] STROBE_MASK = (W'(1) << HALT_BIT) | (W'(1) << IDLE_BIT);

  logic [W-1:0]     data_q, cfg_q, pin_sync, pin_view;
  logic [OUT_W-1:0] dout_q;
  logic [W-1:0]     rd_mux;
  reg_sel_e         wsel, rsel;
  logic             data_wr;

  assign wsel    = reg_sel_e'(wr_addr);
  assign rsel    = reg_sel_e'(rd_addr);
  assign data_wr = wr_en && (wsel == REG_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      cfg_q  <= '0;
      dout_q <= '1;
    end else if (wr_en) begin
      unique case (wsel)
        REG_DATA: data_q <= wdata & ~STROBE_MASK;
        REG_CFG:  cfg_q  <= wdata;
        REG_DOUT: dout_q <= wdata[OUT_W-1:0];
        default:  ;
      endcase
    end
  end

  cfgio_strobe u_halt (.clk(clk), .rst(rst), .fire(data_wr && wdata[HALT_BIT]), .pulse(halt_req));
  cfgio_strobe u_idle (.clk(clk), .rst(rst), .fire(data_wr && wdata[IDLE_BIT]), .pulse(idle_req));

  cfgio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pin_sync)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    cfgio_mode_cell u_cell (
      .cfg_bit(cfg_q[i]), .dat_bit(data_q[i]),
      .drv_out(pad_out[i]), .drv_oe(pad_oe[i]), .pull_en(pad_pu[i])
    );
    if (i < FORCE_LO) begin : g_forced
      assign pin_view[i] = 1'b1;
    end else begin : g_live
      assign pin_view[i] = pin_sync[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (rsel)
      REG_DATA: rd_mux = data_q;
      REG_CFG:  rd_mux = cfg_q;
      REG_PIN:  rd_mux = pin_view;
      REG_DOUT: rd_mux[OUT_W-1:0] = dout_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign dout_port = dout_q;
endmodule

// File: rtl/cfgio_port_chk.sv
module cfgio_port_chk #(
  parameter int W        = 8,
  parameter int OUT_W    = 4,
  parameter int HALT_BIT = 7,
  parameter int IDLE_BIT = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [W-1:0]     wdata,
  input logic             rd_en,
  input logic [W-1:0]     rdata,
  input logic [W-1:0]     pad_out,
  input logic [W-1:0]     pad_oe,
  input logic [W-1:0]     pad_pu,
  input logic             halt_req,
  input logic             idle_req,
  input logic [OUT_W-1:0] dout_port
);
  assert_pu_only_input_R2: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & pad_pu) == '0);

  assert_out_needs_oe_R4: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  assert_reset_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && dout_port == '1 && !halt_req && !idle_req));

  assert_halt_cause_R8: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(wr_en && wr_addr == 2'd0 && wdata[HALT_BIT]));

  assert_idle_cause_R9: assert property (@(posedge clk) disable iff (rst)
    idle_req |-> $past(wr_en && wr_addr == 2'd0 && wdata[IDLE_BIT]));

  assert_dout_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 2'd3) |=> $stable(dout_port));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind cfgio_port cfgio_port_chk #(.W(W), .OUT_W(OUT_W), .HALT_BIT(HALT_BIT), .IDLE_BIT(IDLE_BIT)) u_chk (.*);

// File: tb/cfgio_port_bench.sv
module cfgio_port_bench;
  localparam int W = 8;
  localparam int OUT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wdata = '0, pad_in = '0;
  logic [W-1:0] rdata, pad_out, pad_oe, pad_pu;
  logic halt_req, idle_req;
  logic [OUT_W-1:0] dout_port;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfgio_port u_cfgio_port (.*);

  // stimulus: {config, data}
  localparam logic [15:0] VEC [4] = '{
    16'hF0_0F, 16'h0F_F0, 16'hAA_CC, 16'h33_3C
  };

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5 reset state
    chk("R5 oe", pad_oe, '0);
    chk("R5 pu", pad_pu, '0);
    chk("R10 dout reset", W'(dout_port), W'(4'hF));
    rd(2'd0, v); chk("R5 data reads 0", v, '0);

    // mode table walk (R1..R4, R7)
    foreach (VEC[k]) begin
      wr(2'd1, VEC[k][15:8]);
      wr(2'd0, VEC[k][7:0]);
      d = VEC[k][7:0] & 8'h3F;
      chk("R3 R4 oe", pad_oe, VEC[k][15:8]);
      chk("R4 out", pad_out, VEC[k][15:8] & d);
      chk("R1 R2 pu", pad_pu, ~VEC[k][15:8] & d);
      rd(2'd1, v); chk("R7 cfg readback", v, VEC[k][15:8]);
      rd(2'd0, v); chk("R7 data readback", v, d);
    end

    // R8 halt pulse
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wdata = 8'h81;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 halt high", W'(halt_req), 1);
    chk("R9 idle stays low", W'(idle_req), 0);
    @(negedge clk);
    chk("R8 halt one cycle", W'(halt_req), 0);
    rd(2'd0, v); chk("R8 bit self-clears", v, 8'h01);

    // R9 idle pulse
    wr(2'd0, 8'h40);
    chk("R9 idle high", W'(idle_req), 1);
    @(negedge clk);
    chk("R9 idle one cycle", W'(idle_req), 0);

    // R6 pin path with forced low nibble
    @(negedge clk); pad_in = 8'hA5;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R6 pin A5", v, 8'hAF);
    @(negedge clk); pad_in = 8'h50;
    repeat (2) @(negedge clk);
    rd(2'd2, v); chk("R6 pin 50", v, 8'h5F);

    // R10 output-only port
    wr(2'd3, 8'hF6);
    chk("R10 dout write", W'(dout_port), W'(4'h6));
    rd(2'd3, v); chk("R10 dout read", v, 8'h06);
    wr(2'd1, 8'h00);
    chk("R10 dout untouched", W'(dout_port), W'(4'h6));

    // R11 rdata holds without rd_en
    rd(2'd1, v);
    wr(2'd1, 8'h5A);
    repeat (2) @(negedge clk);
    chk("R11 rdata hold", rdata, 8'h00);

    // R5 mid-run reset
    wr(2'd0, 8'h3F); wr(2'd1, 8'hFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R5 oe after reset", pad_oe, '0);
    chk("R5 dout after reset", W'(dout_port), W'(4'hF));
    rd(2'd1, v); chk("R5 cfg cleared", v, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule